// File: doc/BRIEF.md
# Power-of-Two Sample Read Strobe Generator

This block paces how fast samples are pulled from a sample FIFO into a datapath whose clock never changes. A single free-running binary counter advances on every clock. Each counter bit has its own detector that fires for one cycle when the bit drops from 1 to 0. A rate code picks one of these detectors, and the chosen pulse becomes the FIFO read enable. Since bit k of a binary counter falls once every 2^(k+1) cycles, the read rate is always the clock rate divided by a power of two. The spacing between reads is exact and constant, with no drift.

The block has a second output, a "new sample" flag. This flag is the read strobe delayed by one cycle. It marks the cycle in which the freshly read FIFO word is present for the interpolation stages that follow.

A synchronous reset restarts the timing. Any change of the rate code also restarts it: the counter and the edge history are cleared, and no strobe is produced in the cycle in which the change is seen. A strobe therefore never falls in a cycle where the old and new cadences would overlap.

Top module: `rate_strobe_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_strobe` and `new_sample` are 0.
- R2: With a steady rate code k, `rd_strobe` is 1 exactly in the cycles that lie a whole multiple of 2^(k+1) clock edges after the last restart. The restart is the last reset edge or rate-change edge, and the count of edges must be nonzero.
- R3: `rd_strobe` is never high in two consecutive cycles.
- R4: A rate change restarts the cadence. `rate_sel` differing from its value at the previous clock edge counts as a change. After the change, the first strobe comes 2^(k+1) edges after the changing edge, where k is the new code.
- R5: In a cycle where a rate change is seen, `rd_strobe` is 0, even if a strobe of the old cadence was due in that cycle.
- R6: `new_sample` equals the value `rd_strobe` had in the previous cycle. It is 0 in the cycle after a reset edge.
- R7: The rate code is a 3-bit unsigned value selecting counter bit k. Code 0 gives one strobe every 2 cycles, and code 7 gives one strobe every 256 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed-rate output-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 3 | Rate code k; read period is 2^(k+1) cycles |
| rd_strobe | output | 1 | One-cycle FIFO read enable |
| new_sample | output | 1 | Read strobe delayed one cycle: new word is present |

## Verification
The two functions that can collide are the normal strobe cadence and the rate-change restart. A code change can arrive in exactly the cycle where the old cadence would raise the read enable. The bench provokes this by running a code until its model says a strobe is due, and then switching the code in that very cycle. It judges the outcome by requiring the strobe to stay low in that cycle. It then requires the new cadence to begin its first full period from that edge. A mid-run reset is placed on a due cycle in the same way.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  // Number of clock cycles between read strobes for rate code k.
  function automatic int unsigned strobe_period(input int unsigned code);
    return 32'd1 << (code + 1);
  endfunction

endpackage

// File: rtl/rsg_counter.sv
module rsg_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (clr) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/rsg_fall_detect.sv
module rsg_fall_detect #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] fall
);

  logic [CNT_W-1:0] prev;

  for (genvar b = 0; b < CNT_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (clr) prev[b] <= 1'b0;
      else     prev[b] <= cnt[b];
    end
    assign fall[b] = prev[b] & ~cnt[b];
  end

endmodule

// File: rtl/rsg_select.sv
module rsg_select #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic [CNT_W-1:0] fall,
  input  logic [SEL_W-1:0] sel,
  output logic             pick
);

  localparam int NCODE = 1 << SEL_W;

  logic [NCODE-1:0] cand;

  for (genvar i = 0; i < NCODE; i++) begin : g_cand
    if (i < CNT_W) begin : g_live
      assign cand[i] = fall[i];
    end else begin : g_dead
      assign cand[i] = 1'b0;
    end
  end

  assign pick = cand[sel];

endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             rd_strobe,
  output logic             new_sample
);
  import rsg_pkg::*;

  localparam int GAP_W = CNT_W + 2;

  logic [SEL_W-1:0] sel_q;
  logic             sel_chg;
  logic             restart;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] fall;
  logic             pick;

  // Rate code seen at the previous edge; a difference is a change event.
  always_ff @(posedge clk) sel_q <= rate_sel;

  assign sel_chg = !rst && (rate_sel != sel_q);
  assign restart = rst | sel_chg;

  rsg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .clr (restart),
    .cnt (cnt)
  );

  rsg_fall_detect #(.CNT_W(CNT_W)) u_fall (
    .clk  (clk),
    .clr  (restart),
    .cnt  (cnt),
    .fall (fall)
  );

  rsg_select #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_sel (
    .fall (fall),
    .sel  (sel_q),
    .pick (pick)
  );

  assign rd_strobe = pick & ~restart;

  always_ff @(posedge clk) begin
    if (rst) new_sample <= 1'b0;
    else     new_sample <= rd_strobe;
  end

  // Cycles since last restart or strobe, kept for the cadence assertions.
  logic [GAP_W-1:0] gap;
  logic [GAP_W-1:0] per_now;

  always_ff @(posedge clk) begin
    if (restart)        gap <= '0;
    else if (rd_strobe) gap <= GAP_W'(1);
    else                gap <= gap + 1'b1;
  end

  assign per_now = GAP_W'(strobe_period(32'(sel_q)));

  assert_period_R2: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |-> (gap == per_now));

  assert_no_miss_R2: assert property (@(posedge clk) disable iff (rst)
    gap <= per_now);

  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> !rd_strobe);

  assert_quiet_after_restart_R4: assert property (@(posedge clk) disable iff (rst)
    restart |=> !rd_strobe);

  assert_flag_delay_R6: assert property (@(posedge clk) disable iff (rst)
    new_sample == $past(rd_strobe));

endmodule

// File: tb/rate_strobe_gen_test.sv
module rate_strobe_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rate_sel = 3'd2;
  logic       rd_strobe;
  logic       new_sample;

  always #4 clk = ~clk;

  rate_strobe_gen uut (
    .clk        (clk),
    .rst        (rst),
    .rate_sel   (rate_sel),
    .rd_strobe  (rd_strobe),
    .new_sample (new_sample)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  int    n      = 0;
  int    sel_prev = 2;
  bit    exp_ns = 1'b0;
  bit    prev_act = 1'b0;
  string req = "R1";

  function automatic int period_of(input int k);
    return 2 ** (k + 1);
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b (n=%0d code=%0d)",
               tag, act, exp, n, sel_prev);
    end
  endtask

  task automatic step(input bit r, input int s);
    bit    chg;
    bit    exp_s;
    string tag;
    @(negedge clk);
    rst      = r;
    rate_sel = 3'(s);
    #1;
    chg   = !r && (s != sel_prev);
    exp_s = !r && !chg && (n > 0) && (n % period_of(sel_prev) == 0);
    tag   = chg ? "R5" : req;
    check(tag, rd_strobe, exp_s);
    check("R6", new_sample, exp_ns);
    checks++;
    if (prev_act && rd_strobe) begin
      fails++;
      $display("FAIL R3: actual=1 expected=0 (strobe two cycles running)");
    end
    prev_act = rd_strobe;
    n        = (r || chg) ? 0 : n + 1;
    exp_ns   = exp_s;
    sel_prev = s;
  endtask

  initial begin
    // R1: reset state and first cycle after reset
    req = "R1";
    repeat (3) step(1'b1, 2);
    repeat (2) step(1'b0, 2);
    req = "R2";
    repeat (30) step(1'b0, 2);

    // R2/R4/R7: sweep every code; each switch restarts the cadence
    for (int k = 0; k < 8; k++) begin
      req = "R4";
      step(1'b0, k);
      req = ((k == 0) || (k == 7)) ? "R7" : "R2";
      repeat (3 * period_of(k) + 2) step(1'b0, k);
    end

    // R5: code change lands exactly on a due strobe of code 1
    req = "R2";
    repeat (5) step(1'b0, 1);
    while (!((n > 0) && (n % 4 == 0))) step(1'b0, 1);
    step(1'b0, 3);
    req = "R4";
    repeat (40) step(1'b0, 3);

    // R1: mid-run reset on a due strobe of code 3
    while (!((n > 0) && (n % 16 == 0))) step(1'b0, 3);
    req = "R1";
    step(1'b1, 3);
    repeat (40) step(1'b0, 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule